// File: doc/BRIEF.md
# Serial Input Interrupt Unit

This block raises interrupts from the input side of a serial GPIO chain. The chain hardware (outside this block) deserializes up to `NBITS` bit indices for each of `NPORTS` ports and presents the result as `NBITS` words, one word per bit index, with the port number as the bit position. Each time a fresh set of words is ready, the chain pulses `sample_stb` for one clock.

Each pin `(port, bit)` has an enable, a two-bit trigger type and a polarity. The trigger type is split across two register banks. One bank holds the low bits and the other holds the high bits. The type selects one of four detectors: level, any edge, falling edge or rising edge. Edge events set a sticky pending bit, which software clears by writing ones to an acknowledge word. Level mode is not sticky: it shows the last sampled level, qualified by the polarity. An identity word per bit index shows the pins that are both pending and enabled. The single interrupt line is the OR of all identity bits, gated by a master enable.

Software reaches the registers through a flat read/write port. Writes take effect at the clock edge. Reads are combinational.

Top module: `serin_irq_unit`

## Requirements
- R1: After reset, all enable words, trigger words, polarity words and the master enable are zero. Every identity word reads zero and `irq` is low.
- R2: Address map (N = `NBITS`, b = bit index):
  - enable word b is at address b.
  - trigger-low word b is at N+b and trigger-high word b is at 2N+b.
  - polarity word b is at 3N+b.
  - acknowledge word b is at 4N+b and always reads zero.
  - identity word b is at 5N+b and is read-only.
  - the master enable is bit 0 at address 6N.
  - Writable words read back the value last written.
- R3: Trigger type {high,low} = 3 (rising) sets a pin's pending bit on a strobe where the pin's sample goes from 0 to 1, and not on a 1-to-0 change.
- R4: Trigger type 2 (falling) sets pending only on a strobe where the sample goes from 1 to 0.
- R5: Trigger type 1 (any edge) sets pending on both 0-to-1 and 1-to-0 sample changes.
- R6: Trigger type 0 (level) shows the pin as active while (last sampled value XOR polarity bit) is 1. Polarity 0 means active high and 1 means active low. An acknowledge write has no lasting effect on a level pin while its level persists.
- R7: Edges are judged only on cycles with `sample_stb` high, against the sample taken at the previous strobe (zero after reset). Input changes without a strobe have no effect.
- R8: Writing an acknowledge word clears the pending bits at positions written with 1 and leaves those written with 0 unchanged.
- R9: When an edge event and an acknowledge of the same pin fall in the same cycle, the pin remains pending.
- R10: The identity word b equals (pending or active level) AND enable word b. A disabled pin still records edge events and appears in the identity word as soon as it is enabled.
- R11: `irq` is high exactly when the master enable is 1 and some identity bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | One-cycle pulse that marks a new deserialized sample |
| sample_data | input | NBITS*NPORTS | Sample words; word b occupies bits [b*NPORTS +: NPORTS] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(6*NBITS+1) | Register address |
| reg_wdata | input | NPORTS | Register write data |
| reg_rdata | output | NPORTS | Register read data (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The sensitive overlap is an acknowledge write and a sample strobe that both reach the same pin in the same clock. Here the acknowledge clears the old event while the strobe detects a new one. The bench sets a pin to pending under any-edge mode. It then drives, on one clock edge, a strobe that toggles the pin together with an acknowledge of that pin. It judges the result from the identity word, which must still show the pin until a later, separate acknowledge clears it.

// File: rtl/serin_irq_unit.sv
module serin_irq_unit #(
  parameter int NPORTS = 32,
  parameter int NBITS  = 4,
  localparam int AW    = $clog2(6*NBITS+1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_stb,
  input  logic [NBITS*NPORTS-1:0] sample_data,
  input  logic                    reg_we,
  input  logic [AW-1:0]           reg_addr,
  input  logic [NPORTS-1:0]       reg_wdata,
  output logic [NPORTS-1:0]       reg_rdata,
  output logic                    irq
);
  localparam int A_ENA = 0;
  localparam int A_TLO = NBITS;
  localparam int A_THI = 2*NBITS;
  localparam int A_POL = 3*NBITS;
  localparam int A_ACK = 4*NBITS;
  localparam int A_IDT = 5*NBITS;
  localparam int A_CFG = 6*NBITS;

  logic [NPORTS-1:0] ena_q [NBITS];
  logic [NPORTS-1:0] tlo_q [NBITS];
  logic [NPORTS-1:0] thi_q [NBITS];
  logic [NPORTS-1:0] pol_q [NBITS];
  logic [NPORTS-1:0] smp_q [NBITS];
  logic [NPORTS-1:0] pend_q[NBITS];
  logic [NPORTS-1:0] hit   [NBITS];
  logic [NBITS*NPORTS-1:0] ident_flat;
  logic master_q;

  function automatic logic at(input logic [AW-1:0] a, input int base, input int b);
    return a == AW'(base + b);
  endfunction

  always_comb begin
    logic [NPORTS-1:0] cur, rise, fall;
    for (int b = 0; b < NBITS; b++) begin
      cur  = sample_data[b*NPORTS +: NPORTS];
      rise = cur & ~smp_q[b];
      fall = ~cur & smp_q[b];
      hit[b] = sample_stb ? ((tlo_q[b] & rise) |
                             (thi_q[b] & ~tlo_q[b] & fall) |
                             (tlo_q[b] & ~thi_q[b] & fall)) : '0;
      ident_flat[b*NPORTS +: NPORTS] = ena_q[b] &
        ((~tlo_q[b] & ~thi_q[b] & (smp_q[b] ^ pol_q[b])) |
         ((tlo_q[b] | thi_q[b]) & pend_q[b]));
    end
  end

  assign irq = master_q & (|ident_flat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      for (int b = 0; b < NBITS; b++) begin
        ena_q[b]  <= '0;
        tlo_q[b]  <= '0;
        thi_q[b]  <= '0;
        pol_q[b]  <= '0;
        smp_q[b]  <= '0;
        pend_q[b] <= '0;
      end
    end else begin
      if (reg_we && reg_addr == AW'(A_CFG)) master_q <= reg_wdata[0];
      for (int b = 0; b < NBITS; b++) begin
        if (reg_we && at(reg_addr, A_ENA, b)) ena_q[b] <= reg_wdata;
        if (reg_we && at(reg_addr, A_TLO, b)) tlo_q[b] <= reg_wdata;
        if (reg_we && at(reg_addr, A_THI, b)) thi_q[b] <= reg_wdata;
        if (reg_we && at(reg_addr, A_POL, b)) pol_q[b] <= reg_wdata;
        if (sample_stb) smp_q[b] <= sample_data[b*NPORTS +: NPORTS];
        pend_q[b] <= (pend_q[b] & ~((reg_we && at(reg_addr, A_ACK, b)) ? reg_wdata : '0))
                     | hit[b];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CFG)) reg_rdata = NPORTS'(master_q);
    for (int b = 0; b < NBITS; b++) begin
      if (at(reg_addr, A_ENA, b)) reg_rdata = ena_q[b];
      if (at(reg_addr, A_TLO, b)) reg_rdata = tlo_q[b];
      if (at(reg_addr, A_THI, b)) reg_rdata = thi_q[b];
      if (at(reg_addr, A_POL, b)) reg_rdata = pol_q[b];
      if (at(reg_addr, A_IDT, b)) reg_rdata = ident_flat[b*NPORTS +: NPORTS];
    end
  end
endmodule

// File: rtl/serin_irq_unit_chk.sv
module serin_irq_unit_chk #(
  parameter int NPORTS = 32,
  parameter int NBITS  = 4,
  localparam int AW    = $clog2(6*NBITS+1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_stb,
  input logic                    reg_we,
  input logic [AW-1:0]           reg_addr,
  input logic [NPORTS-1:0]       reg_wdata,
  input logic                    irq,
  input logic [NBITS*NPORTS-1:0] ident_flat
);
  localparam int A_CFG = 6*NBITS;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq); // R1

  AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_stb && !reg_we) |=> ($stable(ident_flat) && $stable(irq))); // R7

  AST_MASTER_OFF_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(A_CFG) && !reg_wdata[0]) |=> !irq); // R11

  for (genvar b = 0; b < NBITS; b++) begin : g_ena
    AST_DISABLED_WORD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == AW'(b) && reg_wdata == '0)
        |=> (ident_flat[b*NPORTS +: NPORTS] == '0)); // R10
  end
endmodule

bind serin_irq_unit serin_irq_unit_chk #(.NPORTS(NPORTS), .NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq), .ident_flat(ident_flat)
);

// File: tb/serin_irq_unit_bench.sv
module serin_irq_unit_bench;
  localparam int NP = 32, NB = 4;
  localparam int ENA = 0, TLO = 4, THI = 8, POL = 12, ACK = 16, IDT = 20, CFG = 24;

  logic clk = 0, rst_n = 0, sample_stb = 0, reg_we = 0, irq;
  logic [NB*NP-1:0] sample_data = '0, din = '0;
  logic [4:0] reg_addr = '0;
  logic [NP-1:0] reg_wdata = '0, reg_rdata;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serin_irq_unit u_serin_irq_unit (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .sample_data(sample_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic chkreg(input string req, input int a, input logic [31:0] exp);
    @(negedge clk); reg_addr = 5'(a); #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic strobe();
    @(negedge clk); sample_data = din; sample_stb = 1;
    @(negedge clk); sample_stb = 0;
  endtask

  task automatic setup(input int b, input int p, input logic [1:0] typ, input bit en);
    wr(TLO + b, 32'(typ[0]) << p);
    wr(THI + b, 32'(typ[1]) << p);
    wr(ACK + b, 32'hFFFF_FFFF);
    wr(ENA + b, en ? (32'd1 << p) : 32'd0);
  endtask

  task automatic t_reset();
    for (int b = 0; b < NB; b++) begin
      chkreg("R1 enable", ENA + b, 0);
      chkreg("R1 ident", IDT + b, 0);
    end
    chkreg("R1 master", CFG, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_map();
    wr(TLO + 1, 32'h1234_5678); chkreg("R2 trig low", TLO + 1, 32'h1234_5678);
    wr(THI + 2, 32'h8765_4321); chkreg("R2 trig high", THI + 2, 32'h8765_4321);
    wr(POL + 0, 32'hA5A5_0F0F); chkreg("R2 polarity", POL + 0, 32'hA5A5_0F0F);
    wr(ENA + 3, 32'h0000_FFFF); chkreg("R2 enable", ENA + 3, 32'h0000_FFFF);
    wr(ACK + 0, 32'hFFFF_FFFF); chkreg("R2 ack reads zero", ACK + 0, 0);
    wr(TLO + 1, 0); wr(THI + 2, 0); wr(POL + 0, 0); wr(ENA + 3, 0);
  endtask

  task automatic t_rise();
    setup(1, 5, 2'd3, 1); wr(CFG, 1);
    din[1*NP+5] = 1; strobe();
    chkreg("R3 rise pending", IDT + 1, 32'd1 << 5);
    chk("R11 irq on", 32'(irq), 1);
    wr(ACK + 1, 32'd1 << 5);
    chkreg("R3 ack clears", IDT + 1, 0);
    din[1*NP+5] = 0; strobe();
    chkreg("R3 fall ignored", IDT + 1, 0);
    chk("R11 irq off", 32'(irq), 0);
    wr(ENA + 1, 0);
  endtask

  task automatic t_fall();
    setup(2, 7, 2'd2, 1);
    din[2*NP+7] = 1; strobe();
    chkreg("R4 rise ignored", IDT + 2, 0);
    din[2*NP+7] = 0; strobe();
    chkreg("R4 fall pending", IDT + 2, 32'd1 << 7);
    wr(ACK + 2, 32'd1 << 7);
    chkreg("R4 ack clears", IDT + 2, 0);
    wr(ENA + 2, 0);
  endtask

  task automatic t_both();
    setup(0, 0, 2'd1, 1);
    din[0] = 1; strobe();
    chkreg("R5 rise pending", IDT + 0, 1);
    wr(ACK + 0, 1);
    chkreg("R5 cleared", IDT + 0, 0);
    din[0] = 0; strobe();
    chkreg("R5 fall pending", IDT + 0, 1);
    wr(ACK + 0, 1);
    wr(ENA + 0, 0);
  endtask

  task automatic t_level();
    setup(3, 31, 2'd0, 1); wr(POL + 3, 0);
    chkreg("R6 idle low", IDT + 3, 0);
    din[3*NP+31] = 1; strobe();
    chkreg("R6 high active", IDT + 3, 32'h8000_0000);
    wr(ACK + 3, 32'h8000_0000);
    chkreg("R6 ack no effect", IDT + 3, 32'h8000_0000);
    wr(POL + 3, 32'h8000_0000);
    chkreg("R6 inverted idle", IDT + 3, 0);
    din[3*NP+31] = 0; strobe();
    chkreg("R6 low active", IDT + 3, 32'h8000_0000);
    din[3*NP+31] = 1; strobe();
    chkreg("R6 not sticky", IDT + 3, 0);
    wr(POL + 3, 0); wr(ENA + 3, 0);
  endtask

  task automatic t_nostrobe();
    setup(0, 3, 2'd3, 1);
    din[3] = 1;
    @(negedge clk); sample_data = din;
    repeat (4) @(negedge clk);
    chkreg("R7 no strobe no edge", IDT + 0, 0);
    strobe();
    chkreg("R7 edge at strobe", IDT + 0, 32'd1 << 3);
    wr(ACK + 0, 32'd1 << 3); wr(ENA + 0, 0);
  endtask

  task automatic t_ackzero();
    setup(3, 20, 2'd3, 1);
    din[3*NP+20] = 1; strobe();
    wr(ACK + 3, 0);
    chkreg("R8 zero ack keeps", IDT + 3, 32'd1 << 20);
    wr(ACK + 3, 32'd1 << 21);
    chkreg("R8 other bit keeps", IDT + 3, 32'd1 << 20);
    wr(ACK + 3, 32'd1 << 20);
    chkreg("R8 own bit clears", IDT + 3, 0);
    wr(ENA + 3, 0);
  endtask

  task automatic t_collide();
    setup(1, 9, 2'd1, 1);
    din[1*NP+9] = 1; strobe();
    chkreg("R9 first edge", IDT + 1, 32'd1 << 9);
    din[1*NP+9] = 0;
    @(negedge clk);
    sample_data = din; sample_stb = 1;
    reg_we = 1; reg_addr = 5'(ACK + 1); reg_wdata = 32'd1 << 9;
    @(negedge clk); sample_stb = 0; reg_we = 0;
    chkreg("R9 edge beats ack", IDT + 1, 32'd1 << 9);
    wr(ACK + 1, 32'd1 << 9);
    chkreg("R9 later ack clears", IDT + 1, 0);
    wr(ENA + 1, 0);
  endtask

  task automatic t_disabled();
    setup(2, 12, 2'd3, 0); wr(CFG, 1);
    din[2*NP+12] = 1; strobe();
    chkreg("R10 disabled hidden", IDT + 2, 0);
    chk("R10 irq quiet", 32'(irq), 0);
    wr(ENA + 2, 32'd1 << 12);
    chkreg("R10 recorded while disabled", IDT + 2, 32'd1 << 12);
    chk("R11 irq with master", 32'(irq), 1);
    wr(CFG, 0);
    chk("R11 master gates", 32'(irq), 0);
    chkreg("R11 cfg readback", CFG, 0);
    wr(CFG, 1);
    chk("R11 master back on", 32'(irq), 1);
    wr(ACK + 2, 32'd1 << 12);
    chk("R11 irq after ack", 32'(irq), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset(); t_map(); t_rise(); t_fall(); t_both(); t_level();
    t_nostrobe(); t_ackzero(); t_collide(); t_disabled();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule